// File: doc/BRIEF.md
# AAL5 Receive Reassembly Status Tracker

This block follows the cells of a single AAL5 connection as they are received. It builds the completion status record of the packet being reassembled. Cells arrive as a byte stream with a valid strobe, one byte per accepted clock. Each cell is a 4-byte ATM header with no HEC, followed by 48 payload bytes, and cells sit back to back with no extra framing.

While a packet is open, the block does four things:
- It keeps sticky cell-loss-priority and congestion bits.
- It records the header of the first cell and the header of the last cell.
- It runs the AAL5 CRC-32 over the payload.
- It captures the trailer fields.

When the end-of-packet cell finishes, or when the reassembly timer runs out, it emits a one-cycle record strobe. The record fields hold their values until the next record. A single connection context is kept in registers and cleared after every record.

Top module: `aal5_rx_status`

## Requirements
- R1: After reset, `rec_valid_o`, `done_o`, `error_o`, `err_o`, `clp_o`, `cong_o`, `label_o`, `len_o` and both header outputs are zero.
- R2: A cell ends the packet when bit 3 of header byte 3 is 0 and bit 1 is 1. `rec_valid_o` is high for exactly the cycle after the edge that accepts that cell's last byte. In every record, `done_o` is 1, `label_o` is 0x5241 and `rsvd_o` is 0. The fields hold until the next record.
- R3: `clp_o` is the OR of bit 0 of header byte 3 over all cells of the packet.
- R4: `cong_o` is the OR of bit 2 of header byte 3 over those cells of the packet where bit 3 of that byte is 0.
- R5: `first_hdr_o` and `last_hdr_o` hold the 4 header bytes of the first and last cells. The first received byte is placed in bits 31:24.
- R6: The CRC-32 uses polynomial 0x04C11DB7, most significant bit first, preset to all ones, with the result inverted. It covers every payload byte except the last 4 of the final cell. The last 4 bytes are the received CRC, big-endian. A mismatch sets `err_o[0]`.
- R7: The CPI byte is payload byte 41 of the final cell. A non-zero CPI sets `err_o[1]`.
- R8: The length field is payload bytes 42 (high) and 43 (low) of the final cell, and it is output on `len_o`. For an n-cell packet, a non-zero length L is accepted only when (n−1)·48−8 < L ≤ n·48−8. Any other non-zero length sets `err_o[2]`.
- R9: A length field of zero marks a forward abort. It sets `err_o[3]` and does not set `err_o[2]`.
- R10: A packet with more cells than `max_cells_i` sets `err_o[4]`. A packet with exactly `max_cells_i` cells does not.
- R11: The timeout starts once the open packet has at least one complete cell. If `valid_i` then stays low for `TIMEOUT_CYC` consecutive cycles, a record is emitted with only `err_o[5]` and `error_o` set among the status bits, with `clp_o` and `cong_o` at 0 and `len_o` at 0. Any partial cell is dropped, and the next packet starts clean.
- R12: `error_o` is the OR of all bits of `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte strobe |
| data_i | input | 8 | Cell byte |
| max_cells_i | input | CNT_W | Largest allowed packet, in cells |
| rec_valid_o | output | 1 | Record strobe, one cycle |
| done_o | output | 1 | Packet completed |
| error_o | output | 1 | Any error flag set |
| err_o | output | 6 | Error flags: 0 CRC, 1 CPI, 2 length, 3 abort, 4 too big, 5 timeout |
| clp_o | output | 1 | OR of cell-loss-priority bits |
| cong_o | output | 1 | OR of congestion bits |
| label_o | output | 16 | Buffer label |
| rsvd_o | output | 4 | Reserved, zero |
| first_hdr_o | output | 32 | Header of the first cell |
| last_hdr_o | output | 32 | Header of the last cell |
| len_o | output | 16 | Trailer length field |

## Verification
A completion record is registered on the same edge that accepts the final byte of the end-of-packet cell. Its strobe is therefore visible from the next falling edge on.

A timeout record appears one cycle after the `TIMEOUT_CYC`-th idle cycle that follows the last accepted byte.

The monitor samples on the falling edge and acts only in cycles where the strobe is high. Expected records are queued in send order, so a record that arrives late, early or out of turn produces a miscompare. A record that is never produced is caught by the final check that the queue is empty.

// File: rtl/aal5_rx_pkg.sv
package aal5_rx_pkg;
  localparam int CELL_BYTES = 52;
  localparam int HDR_BYTES  = 4;
  localparam int PAY_BYTES  = 48;
  localparam int BIDX_W     = $clog2(CELL_BYTES);
  localparam int ERR_W      = 6;

  typedef logic [BIDX_W-1:0] bidx_t;

  // error flag positions
  localparam int EB_CRC   = 0;
  localparam int EB_CPI   = 1;
  localparam int EB_LEN   = 2;
  localparam int EB_ABORT = 3;
  localparam int EB_BIG   = 4;
  localparam int EB_TMO   = 5;

  localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
  localparam logic [15:0] REC_LABEL = 16'h5241;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction
endpackage

// File: rtl/aal5_cell_framer.sv
module aal5_cell_framer
  import aal5_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        valid_i,
  input  logic [7:0]  data_i,
  output logic        hdr_done_o,
  output logic [31:0] hdr_word_o,
  output logic [31:0] cur_hdr_o,
  output logic        pay_valid_o,
  output bidx_t       pay_idx_o,
  output logic        cell_end_o,
  output logic        eop_o
);
  bidx_t       idx_q;
  logic [23:0] hdr_sr_q;
  logic [31:0] cur_hdr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      hdr_sr_q  <= '0;
      cur_hdr_q <= '0;
    end else if (clear_i) begin
      idx_q <= '0;
    end else if (valid_i) begin
      idx_q <= (idx_q == bidx_t'(CELL_BYTES-1)) ? '0 : idx_q + 1'b1;
      if (idx_q < bidx_t'(HDR_BYTES-1)) hdr_sr_q <= {hdr_sr_q[15:0], data_i};
      if (idx_q == bidx_t'(HDR_BYTES-1)) cur_hdr_q <= {hdr_sr_q, data_i};
    end
  end

  assign hdr_word_o  = {hdr_sr_q, data_i};
  assign hdr_done_o  = valid_i && (idx_q == bidx_t'(HDR_BYTES-1));
  assign pay_valid_o = valid_i && (idx_q >= bidx_t'(HDR_BYTES));
  assign pay_idx_o   = idx_q - bidx_t'(HDR_BYTES);
  assign cell_end_o  = valid_i && (idx_q == bidx_t'(CELL_BYTES-1));
  assign cur_hdr_o   = cur_hdr_q;
  // user data cell with user-indication bit set
  assign eop_o       = !cur_hdr_q[3] && cur_hdr_q[1];
endmodule

// File: rtl/aal5_crc_unit.sv
module aal5_crc_unit
  import aal5_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= crc32_step(crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/aal5_reasm_timer.sv
module aal5_reasm_timer #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || kick_i) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && !kick_i && (cnt_q == TW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/aal5_rx_status.sv
module aal5_rx_status
  import aal5_rx_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  input  logic [CNT_W-1:0] max_cells_i,
  output logic             rec_valid_o,
  output logic             done_o,
  output logic             error_o,
  output logic [ERR_W-1:0] err_o,
  output logic             clp_o,
  output logic             cong_o,
  output logic [15:0]      label_o,
  output logic [3:0]       rsvd_o,
  output logic [31:0]      first_hdr_o,
  output logic [31:0]      last_hdr_o,
  output logic [15:0]      len_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic        hdr_done, pay_valid, cell_end, eop, tmo, crc_en, crc_init;
  logic [31:0] hdr_word, cur_hdr, crc;
  bidx_t       pay_idx;

  logic [CNT_W-1:0] cells_q, cells_nxt;
  logic        clp_q, cong_q, big_q;
  logic [31:0] first_q;
  logic [7:0]  cpi_q;
  logic [15:0] len_q;
  logic [23:0] rxcrc_q;

  logic             rec_valid_q, done_q, error_q, clp_r, cong_r;
  logic [ERR_W-1:0] err_q, err_n;
  logic [15:0]      label_q, len_r;
  logic [31:0]      first_r, last_r;
  logic             eop_fin, len_ok;
  int               n_i;

  aal5_cell_framer u_framer (
    .clk_i, .rst_ni, .clear_i(tmo), .valid_i, .data_i,
    .hdr_done_o(hdr_done), .hdr_word_o(hdr_word), .cur_hdr_o(cur_hdr),
    .pay_valid_o(pay_valid), .pay_idx_o(pay_idx), .cell_end_o(cell_end), .eop_o(eop)
  );

  // trailer CRC bytes of the final cell stay out of the running CRC
  assign crc_en   = pay_valid && !(eop && pay_idx >= bidx_t'(PAY_BYTES-4));
  assign eop_fin  = cell_end && eop;
  assign crc_init = eop_fin || tmo;

  aal5_crc_unit u_crc (
    .clk_i, .rst_ni, .init_i(crc_init), .en_i(crc_en), .data_i, .crc_o(crc)
  );

  aal5_reasm_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(cells_q != '0), .kick_i(valid_i), .expire_o(tmo)
  );

  assign cells_nxt = (cells_q == CMAX) ? cells_q : cells_q + 1'b1;

  always_comb begin
    n_i    = int'(cells_nxt);
    len_ok = (int'(len_q) <= n_i * PAY_BYTES - 8) &&
             (int'(len_q) + 8 > (n_i - 1) * PAY_BYTES);
    err_n           = '0;
    err_n[EB_CRC]   = ({rxcrc_q, data_i} != ~crc);
    err_n[EB_CPI]   = (cpi_q != 8'h00);
    err_n[EB_ABORT] = (len_q == 16'h0000);
    err_n[EB_LEN]   = (len_q != 16'h0000) && !len_ok;
    err_n[EB_BIG]   = big_q || (cells_nxt > max_cells_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cells_q <= '0; clp_q <= 1'b0; cong_q <= 1'b0; big_q <= 1'b0;
      first_q <= '0; cpi_q <= '0; len_q <= '0; rxcrc_q <= '0;
      rec_valid_q <= 1'b0; done_q <= 1'b0; error_q <= 1'b0; err_q <= '0;
      clp_r <= 1'b0; cong_r <= 1'b0; label_q <= '0; len_r <= '0;
      first_r <= '0; last_r <= '0;
    end else begin
      rec_valid_q <= 1'b0;
      if (tmo) begin
        rec_valid_q <= 1'b1;
        done_q  <= 1'b1;
        error_q <= 1'b1;
        err_q   <= ERR_W'(1) << EB_TMO;
        clp_r   <= 1'b0;
        cong_r  <= 1'b0;
        label_q <= REC_LABEL;
        len_r   <= '0;
        first_r <= first_q;
        last_r  <= cur_hdr;
        cells_q <= '0; clp_q <= 1'b0; cong_q <= 1'b0; big_q <= 1'b0;
      end else begin
        if (hdr_done) begin
          clp_q  <= clp_q | hdr_word[0];
          cong_q <= cong_q | (!hdr_word[3] && hdr_word[2]);
          if (cells_q == '0) first_q <= hdr_word;
        end
        if (pay_valid && eop) begin
          if (pay_idx == bidx_t'(PAY_BYTES-7)) cpi_q <= data_i;
          if (pay_idx == bidx_t'(PAY_BYTES-6)) len_q[15:8] <= data_i;
          if (pay_idx == bidx_t'(PAY_BYTES-5)) len_q[7:0]  <= data_i;
          if (pay_idx >= bidx_t'(PAY_BYTES-4) && pay_idx < bidx_t'(PAY_BYTES-1))
            rxcrc_q <= {rxcrc_q[15:0], data_i};
        end
        if (cell_end) begin
          if (eop) begin
            rec_valid_q <= 1'b1;
            done_q  <= 1'b1;
            error_q <= |err_n;
            err_q   <= err_n;
            clp_r   <= clp_q;
            cong_r  <= cong_q;
            label_q <= REC_LABEL;
            len_r   <= len_q;
            first_r <= (cells_q == '0) ? cur_hdr : first_q;
            last_r  <= cur_hdr;
            cells_q <= '0; clp_q <= 1'b0; cong_q <= 1'b0; big_q <= 1'b0;
          end else begin
            cells_q <= cells_nxt;
            big_q   <= big_q || (cells_nxt > max_cells_i);
          end
        end
      end
    end
  end

  assign rec_valid_o = rec_valid_q;
  assign done_o      = done_q;
  assign error_o     = error_q;
  assign err_o       = err_q;
  assign clp_o       = clp_r;
  assign cong_o      = cong_r;
  assign label_o     = label_q;
  assign rsvd_o      = 4'h0;
  assign first_hdr_o = first_r;
  assign last_hdr_o  = last_r;
  assign len_o       = len_r;
endmodule

// File: rtl/aal5_rx_status_chk.sv
module aal5_rx_status_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        rec_valid_o,
  input logic        done_o,
  input logic        error_o,
  input logic [5:0]  err_o,
  input logic        clp_o,
  input logic        cong_o,
  input logic [15:0] label_o,
  input logic [3:0]  rsvd_o
);
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o);

  a_r2_record_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (done_o && label_o == 16'h5241 && rsvd_o == 4'h0));

  a_r2_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !err_o[5]) |-> $past(valid_i));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_valid_o |-> ($stable(err_o) && $stable(clp_o) && $stable(cong_o)));

  a_r11_timeout_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && err_o[5]) |-> (err_o[4:0] == 5'd0 && !clp_o && !cong_o && error_o));

  a_r12_error_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (error_o == (err_o != 6'd0)));
endmodule

bind aal5_rx_status aal5_rx_status_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .rec_valid_o(rec_valid_o),
  .done_o(done_o), .error_o(error_o), .err_o(err_o), .clp_o(clp_o),
  .cong_o(cong_o), .label_o(label_o), .rsvd_o(rsvd_o)
);

// File: tb/tb_aal5_rx_status.sv
module tb_aal5_rx_status;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 64;

  typedef struct packed {
    logic        clp;
    logic        cong;
    logic [5:0]  err;
    logic [31:0] first;
    logic [31:0] last;
    logic [15:0] len;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  data = 8'h00;
  logic [7:0]  max_cells = 8'd8;
  logic        rec_valid, done, error, clp, cong;
  logic [5:0]  err;
  logic [15:0] label, len;
  logic [3:0]  rsvd;
  logic [31:0] first_hdr, last_hdr;

  int   n_chk = 0;
  int   n_fail = 0;
  rec_t exp_q[$];
  logic [7:0] pbuf [0:767];

  always #(CLK_PERIOD/2) clk = ~clk;

  aal5_rx_status #(.CNT_W(8), .TIMEOUT_CYC(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(data),
    .max_cells_i(max_cells), .rec_valid_o(rec_valid), .done_o(done),
    .error_o(error), .err_o(err), .clp_o(clp), .cong_o(cong), .label_o(label),
    .rsvd_o(rsvd), .first_hdr_o(first_hdr), .last_hdr_o(last_hdr), .len_o(len)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr_of(input int c, input bit clp_b, input bit cong_b, input bit eop_b);
    return {8'h1C, 8'h2B, 8'(c), 4'h7, 1'b0, cong_b, eop_b, clp_b};
  endfunction

  function automatic logic [31:0] ref_crc(input int nbytes);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < nbytes; i++) begin
      c = c ^ {pbuf[i], 24'h0};
      for (int b = 0; b < 8; b++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    end
    return ~c;
  endfunction

  task automatic send_byte(input logic [7:0] b, input int gap);
    valid = 1'b1; data = b;
    @(posedge clk); #1;
    valid = 1'b0;
    for (int k = 0; k < gap; k++) begin @(posedge clk); #1; end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic send_packet(input int n, input int dlen, input int lenf, input int cpi,
                             input bit bad_crc, input int clp_m, input int cong_m, input int gap);
    int          tot;
    logic [31:0] c, h;
    rec_t        e;
    logic [15:0] lf;
    tot = n * 48;
    lf  = 16'(lenf);
    for (int i = 0; i < tot; i++) pbuf[i] = (i < dlen) ? 8'(i * 13 + n) : 8'h00;
    pbuf[tot-8] = 8'hA5;
    pbuf[tot-7] = 8'(cpi);
    pbuf[tot-6] = lf[15:8];
    pbuf[tot-5] = lf[7:0];
    c = ref_crc(tot - 4);
    if (bad_crc) c = c ^ 32'h1;
    for (int i = 0; i < 4; i++) pbuf[tot-4+i] = c[31-8*i -: 8];
    e.clp  = 1'b0;
    e.cong = 1'b0;
    for (int i = 0; i < n; i++) begin
      e.clp  = e.clp  | clp_m[i];
      e.cong = e.cong | cong_m[i];
    end
    e.err    = '0;
    e.err[0] = bad_crc;                                   // R6
    e.err[1] = (cpi != 0);                                // R7
    e.err[3] = (lenf == 0);                               // R9
    e.err[2] = (lenf != 0) && !(lenf <= tot - 8 && lenf > tot - 56); // R8
    e.err[4] = (n > int'(max_cells));                     // R10
    e.first  = hdr_of(0, clp_m[0], cong_m[0], n == 1);
    e.last   = hdr_of(n - 1, clp_m[n-1], cong_m[n-1], 1'b1);
    e.len    = lf;
    exp_q.push_back(e);
    for (int cl = 0; cl < n; cl++) begin
      h = hdr_of(cl, clp_m[cl], cong_m[cl], cl == n - 1);
      for (int i = 0; i < 4; i++) send_byte(h[31-8*i -: 8], gap);
      for (int i = 0; i < 48; i++) send_byte(pbuf[cl*48+i], gap);
    end
  endtask

  // full non-final cells, then extra bytes of one more cell, then silence
  task automatic send_stall(input int nfull, input int extra);
    rec_t        e;
    logic [31:0] h;
    e.clp   = 1'b0;
    e.cong  = 1'b0;
    e.err   = 6'b100000;
    e.first = hdr_of(0, 1'b1, 1'b1, 1'b0);
    e.last  = (extra >= 4) ? hdr_of(nfull, 1'b0, 1'b0, 1'b0) : hdr_of(nfull - 1, 1'b0, 1'b0, 1'b0);
    e.len   = 16'h0;
    exp_q.push_back(e);
    for (int cl = 0; cl < nfull; cl++) begin
      h = hdr_of(cl, cl == 0, cl == 0, 1'b0);
      for (int i = 0; i < 4; i++) send_byte(h[31-8*i -: 8], 0);
      for (int i = 0; i < 48; i++) send_byte(8'(i), 0);
    end
    h = hdr_of(nfull, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < extra; i++) send_byte((i < 4) ? h[31-8*i -: 8] : 8'h33, 0);
    idle(TMO + 4);
  endtask

  // monitor: pop and compare on each record strobe
  always @(negedge clk) begin
    if (rst_n && rec_valid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected record", 32'd1, 32'd0);
      end else begin
        rec_t e;
        e = exp_q.pop_front();
        chk("R2 done",            {31'd0, done}, 32'd1);
        chk("R2 label",           {16'd0, label}, 32'h5241);
        chk("R2 rsvd",            {28'd0, rsvd}, 32'd0);
        chk("R3 clp",             {31'd0, clp}, {31'd0, e.clp});
        chk("R4 cong",            {31'd0, cong}, {31'd0, e.cong});
        chk("R5 first_hdr",       first_hdr, e.first);
        chk("R5 last_hdr",        last_hdr, e.last);
        chk("R6 crc flag",        {31'd0, err[0]}, {31'd0, e.err[0]});
        chk("R7 cpi flag",        {31'd0, err[1]}, {31'd0, e.err[1]});
        chk("R8 len flag",        {31'd0, err[2]}, {31'd0, e.err[2]});
        chk("R8 len field",       {16'd0, len}, {16'd0, e.len});
        chk("R9 abort flag",      {31'd0, err[3]}, {31'd0, e.err[3]});
        chk("R10 toobig flag",    {31'd0, err[4]}, {31'd0, e.err[4]});
        chk("R11 timeout flag",   {31'd0, err[5]}, {31'd0, e.err[5]});
        chk("R12 error summary",  {31'd0, error}, {31'd0, |e.err});
      end
    end
  end

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 rec_valid", {31'd0, rec_valid}, 32'd0);
    chk("R1 done",      {31'd0, done}, 32'd0);
    chk("R1 error",     {26'd0, error, err}, 32'd0);
    chk("R1 label",     {16'd0, label}, 32'd0);
    chk("R1 headers",   first_hdr | last_hdr, 32'd0);
    chk("R1 len",       {16'd0, len}, 32'd0);

    send_packet(1, 20, 20, 0, 0, 0, 0, 0);           // R2 single cell
    send_packet(3, 100, 100, 0, 0, 2, 4, 0);         // R3 R4 middle/last cells
    send_packet(2, 88, 88, 0, 0, 1, 0, 0);           // R8 upper bound, no pad
    send_packet(2, 41, 41, 0, 0, 0, 1, 0);           // R8 lower bound
    send_packet(2, 40, 40, 0, 0, 0, 0, 0);           // R8 too short for 2 cells
    send_packet(2, 60, 89, 0, 0, 0, 0, 0);           // R8 exceeds capacity
    send_packet(1, 10, 10, 1, 0, 0, 0, 0);           // R7 non-zero CPI
    send_packet(2, 70, 70, 0, 1, 0, 0, 0);           // R6 bad CRC
    send_packet(1, 0, 0, 0, 0, 0, 0, 0);             // R9 abort
    send_packet(2, 50, 50, 0, 0, 3, 3, 2);           // gaps between bytes
    max_cells = 8'd2;
    send_packet(2, 80, 80, 0, 0, 0, 0, 0);           // R10 exactly at limit
    send_packet(3, 120, 120, 0, 0, 0, 0, 0);         // R10 over limit
    max_cells = 8'd8;
    send_stall(2, 0);                                 // R11 idle after full cells
    send_stall(1, 10);                                // R11 idle mid-cell
    send_packet(1, 30, 30, 0, 0, 1, 0, 0);           // R11 clean context after timeout
    idle(TMO + 10);                                   // R11 no timeout with nothing open
    chk("R2 records outstanding", exp_q.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule